// File: doc/BRIEF.md
# External Bus Cycle Sequencer for an 8-bit Processor

This block turns a single core-side transfer request into the timed pin activity of an external bus in which the low address byte and the data share one set of lines. The core supplies a 16-bit address, a cycle kind and, for writes, a data byte. The sequencer accepts the request only while idle. It then steps through the bus states: an address phase with a latch strobe, a strobe phase, optional wait states, a completion phase and, for instruction fetch and interrupt acknowledge, a trailing decode state. When the transfer ends it returns the read byte together with a one-cycle completion pulse.

The block runs from a clock at twice the bus-state rate. Every bus state therefore has a first half and a second half. The half-state edges give the exact placement of the latch pulse, the strobe release, the read-data capture point and the write-data hold time. Wait states come from an external readiness input. Status pins tell external decoders which kind of cycle is running. These pins are valid from the latch pulse until the cycle ends.

Top module: `bus_cycle_seq`

## Requirements
- R1: After synchronous reset, and whenever idle, the block shows req_ready=1, ale=0, rd_n=1, wr_n=1, ad_oe=0, ad_out=0, a_hi=0, {io_m,s1,s0}=000 and done=0.
- R2: A request is taken on a clock edge where req_valid and req_ready are both 1. The next clock begins the first half of T1. req_ready stays 0 from T1 through the last half-state, and the request inputs are ignored during that time.
- R3: ale is 1 only in the first half of T1. Throughout T1, ad_oe=1 and ad_out carries address bits [7:0]. a_hi carries address bits [15:8] from T1 until the cycle ends.
- R4: req_kind codes 0 memory read, 1 memory write, 2 IO read, 3 IO write, 4 opcode fetch, 5 interrupt acknowledge, and 6 or 7 halt. They give {io_m,s1,s0} = 010, 001, 110, 101, 011, 111 and 000 respectively. The value is held from T1 to the end of the cycle.
- R5: For the read kinds (0, 2, 4, 5), ad_oe=0 from T2 to the end of the cycle. rd_n is 0 from the start of T2, through any wait states, to the end of T3.
- R6: For the read kinds, ad_in is captured on the clock edge that ends the first half of T3, which is half a state before rd_n rises. It appears on rdata with done and is held until the next read capture.
- R7: For the write kinds (1, 3), ad_oe=1 with ad_out=write data from T2 to the end of T3. wr_n is 0 from T2 through the first half of T3 and 1 in the second half, so data outlasts the strobe by half a state.
- R8: ready is sampled on the edge that ends the first half of T2 and of each wait state. A 0 adds one wait state (two clocks) with every output identical to T2. The value of ready at any other time has no effect.
- R9: Opcode fetch and interrupt acknowledge add a T4 after T3. In T4, rd_n=1, wr_n=1 and ad_oe=0, while status and a_hi are held.
- R10: done is 1 for exactly one clock, the clock after the final half-state, and req_ready is 1 in that same clock.
- R11: A halt cycle pulses ale and runs exactly T1, T2 and T3 with no strobe. It releases the bus after T1 and never inserts a wait state, whatever the value of ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bus-state rate |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_kind | input | 3 | Cycle kind code (see R4) |
| req_addr | input | 16 | Transfer address |
| req_wdata | input | 8 | Write data byte |
| ready | input | 1 | External readiness; low requests wait states |
| ale | output | 1 | Address latch strobe |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| io_m | output | 1 | High for IO-space and acknowledge cycles |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| a_hi | output | 8 | High address byte |
| ad_out | output | 8 | Value driven onto the shared address/data lines |
| ad_oe | output | 1 | Drive enable for the shared lines |
| ad_in | input | 8 | Value read from the shared lines |
| rdata | output | 8 | Captured read byte |
| done | output | 1 | One-clock completion pulse |

## Verification
Some properties are checked on every clock by the assertions. These are the mutual exclusion of the two strobes, the rule that the shared lines are never driven while rd_n is low and are always driven while wr_n is low, the single-clock width of ale and done, and the stability of status and high address once a cycle is under way. The bench's scenarios cover what only a timeline can show. They check the exact half-state where each strobe falls and rises, the number of wait states inserted for a given ready pattern, and the extra T4 on fetch and acknowledge. They also confirm that halt ignores ready, that ad_in is taken at the single capture edge and no other, and that requests presented while busy are dropped.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    typedef enum logic [2:0] {
        K_MEM_RD = 3'd0,
        K_MEM_WR = 3'd1,
        K_IO_RD  = 3'd2,
        K_IO_WR  = 3'd3,
        K_FETCH  = 3'd4,
        K_INTA   = 3'd5,
        K_HALT   = 3'd6,
        K_HALT2  = 3'd7
    } cyc_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2   = 3'd2,
        ST_TW   = 3'd3,
        ST_T3   = 3'd4,
        ST_T4   = 3'd5
    } bstate_e;

    // {io_m, s1, s0}
    typedef struct packed {
        logic io_m;
        logic s1;
        logic s0;
    } bus_status_t;

    function automatic logic kind_is_read(cyc_kind_e k);
        return (k == K_MEM_RD) || (k == K_IO_RD) || (k == K_FETCH) || (k == K_INTA);
    endfunction

    function automatic logic kind_is_write(cyc_kind_e k);
        return (k == K_MEM_WR) || (k == K_IO_WR);
    endfunction

    function automatic logic kind_has_t4(cyc_kind_e k);
        return (k == K_FETCH) || (k == K_INTA);
    endfunction

    function automatic logic kind_is_halt(cyc_kind_e k);
        return (k == K_HALT) || (k == K_HALT2);
    endfunction

    function automatic bus_status_t kind_status(cyc_kind_e k);
        bus_status_t s;
        case (k)
            K_MEM_RD: s = '{io_m: 1'b0, s1: 1'b1, s0: 1'b0};
            K_MEM_WR: s = '{io_m: 1'b0, s1: 1'b0, s0: 1'b1};
            K_IO_RD:  s = '{io_m: 1'b1, s1: 1'b1, s0: 1'b0};
            K_IO_WR:  s = '{io_m: 1'b1, s1: 1'b0, s0: 1'b1};
            K_FETCH:  s = '{io_m: 1'b0, s1: 1'b1, s0: 1'b1};
            K_INTA:   s = '{io_m: 1'b1, s1: 1'b1, s0: 1'b1};
            default:  s = '{io_m: 1'b0, s1: 1'b0, s0: 1'b0};
        endcase
        return s;
    endfunction

endpackage

// File: rtl/bcs_fsm.sv
module bcs_fsm
    import bcs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [2:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              ready,
    output bstate_e           state,
    output logic              half,
    output cyc_kind_e         kind_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic              last_tick
);

    logic rdy_q;
    logic in_strobe_phase;

    assign in_strobe_phase = (state == ST_T2) || (state == ST_TW);
    assign last_tick = half && (((state == ST_T3) && !kind_has_t4(kind_q)) || (state == ST_T4));

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            half    <= 1'b0;
            rdy_q   <= 1'b1;
            kind_q  <= K_MEM_RD;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (state == ST_IDLE) begin
            half <= 1'b0;
            if (req_valid) begin
                state   <= ST_T1;
                kind_q  <= cyc_kind_e'(req_kind);
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
        end else begin
            half <= ~half;
            if (!half) begin
                if (in_strobe_phase) begin
                    rdy_q <= ready;
                end
            end else begin
                case (state)
                    ST_T1: state <= ST_T2;
                    ST_T2, ST_TW: begin
                        if (kind_is_halt(kind_q) || rdy_q) begin
                            state <= ST_T3;
                        end else begin
                            state <= ST_TW;
                        end
                    end
                    ST_T3: state <= kind_has_t4(kind_q) ? ST_T4 : ST_IDLE;
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/bcs_drive.sv
module bcs_drive
    import bcs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    localparam int HI_W = ADDR_W - DATA_W
) (
    input  bstate_e           state,
    input  logic              half,
    input  cyc_kind_e         kind_q,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [DATA_W-1:0] wdata_q,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              ad_oe,
    output logic [DATA_W-1:0] ad_out,
    output logic [HI_W-1:0]   a_hi,
    output bus_status_t       status
);

    logic busy, in_t1, strobe_span, is_rd, is_wr;

    always_comb begin
        busy        = (state != ST_IDLE);
        in_t1       = (state == ST_T1);
        strobe_span = (state == ST_T2) || (state == ST_TW) || (state == ST_T3);
        is_rd       = kind_is_read(kind_q);
        is_wr       = kind_is_write(kind_q);

        ale    = in_t1 && !half;
        rd_n   = !(is_rd && strobe_span);
        wr_n   = !(is_wr && (strobe_span && !((state == ST_T3) && half)));
        ad_oe  = in_t1 || (is_wr && strobe_span);
        ad_out = '0;
        if (in_t1) begin
            ad_out = addr_q[DATA_W-1:0];
        end else if (ad_oe) begin
            ad_out = wdata_q;
        end
        a_hi   = busy ? addr_q[ADDR_W-1:DATA_W] : '0;
        status = busy ? kind_status(kind_q) : '0;
    end

endmodule

// File: rtl/bcs_capture.sv
module bcs_capture
    import bcs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  bstate_e           state,
    input  logic              half,
    input  cyc_kind_e         kind_q,
    input  logic              last_tick,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] rdata,
    output logic              done
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
            done  <= 1'b0;
        end else begin
            done <= last_tick;
            if ((state == ST_T3) && !half && kind_is_read(kind_q)) begin
                rdata <= ad_in;
            end
        end
    end

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
    import bcs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    localparam int HI_W = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              ready,
    output logic              ale,
    output logic              s1,
    output logic              s0,
    output logic              io_m,
    output logic              rd_n,
    output logic              wr_n,
    output logic [HI_W-1:0]   a_hi,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] rdata,
    output logic              done
);

    bstate_e           state;
    logic              half;
    cyc_kind_e         kind_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              last_tick;
    bus_status_t       status;

    bcs_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .ready     (ready),
        .state     (state),
        .half      (half),
        .kind_q    (kind_q),
        .addr_q    (addr_q),
        .wdata_q   (wdata_q),
        .last_tick (last_tick)
    );

    bcs_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drive (
        .state   (state),
        .half    (half),
        .kind_q  (kind_q),
        .addr_q  (addr_q),
        .wdata_q (wdata_q),
        .ale     (ale),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .ad_oe   (ad_oe),
        .ad_out  (ad_out),
        .a_hi    (a_hi),
        .status  (status)
    );

    bcs_capture #(.DATA_W(DATA_W)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .state     (state),
        .half      (half),
        .kind_q    (kind_q),
        .last_tick (last_tick),
        .ad_in     (ad_in),
        .rdata     (rdata),
        .done      (done)
    );

    assign req_ready = (state == ST_IDLE);
    assign io_m      = status.io_m;
    assign s1        = status.s1;
    assign s0        = status.s0;

endmodule

// File: rtl/bus_cycle_seq_chk.sv
module bus_cycle_seq_chk #(
    parameter int HI_W = 8,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              ale,
    input logic              s1,
    input logic              s0,
    input logic              io_m,
    input logic              rd_n,
    input logic              wr_n,
    input logic [HI_W-1:0]   a_hi,
    input logic [DATA_W-1:0] ad_out,
    input logic              ad_oe,
    input logic              done
);

    // R2
    ale_busy_chk: assert property (@(posedge clk) disable iff (rst) ale |-> !req_ready);

    // R3
    ale_single_chk: assert property (@(posedge clk) disable iff (rst) ale |=> !ale);

    // R3
    hi_addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!req_ready && !ale && $past(!req_ready)) |-> $stable(a_hi));

    // R4
    status_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!req_ready && !ale && $past(!req_ready)) |-> $stable({io_m, s1, s0}));

    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst) rd_n || wr_n);

    // R5
    rd_float_chk: assert property (@(posedge clk) disable iff (rst) !rd_n |-> !ad_oe);

    // R7
    wr_drive_chk: assert property (@(posedge clk) disable iff (rst) !wr_n |-> ad_oe);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (rd_n && wr_n && !ale && !ad_oe && ad_out == '0));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (rst) done |-> req_ready);

endmodule

bind bus_cycle_seq bus_cycle_seq_chk u_chk (.*);

// File: tb/bus_cycle_seq_bench.sv
module bus_cycle_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 20000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [2:0] req_kind = 3'd0;
    logic [15:0] req_addr = 16'h0;
    logic [7:0] req_wdata = 8'h0;
    logic       ready = 1'b1;
    logic       ale, s1, s0, io_m, rd_n, wr_n, ad_oe, done;
    logic [7:0] a_hi, ad_out, rdata;
    logic [7:0] ad_in = 8'h00;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit finished = 0;
    logic [7:0] model_rdata = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_cycle_seq u_bus_cycle_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
        .ready(ready), .ale(ale), .s1(s1), .s0(s0), .io_m(io_m),
        .rd_n(rd_n), .wr_n(wr_n), .a_hi(a_hi), .ad_out(ad_out),
        .ad_oe(ad_oe), .ad_in(ad_in), .rdata(rdata), .done(done)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h at t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [2:0] exp_status(input int k);
        case (k)
            0: return 3'b010;
            1: return 3'b001;
            2: return 3'b110;
            3: return 3'b101;
            4: return 3'b011;
            5: return 3'b111;
            default: return 3'b000;
        endcase
    endfunction

    task automatic chk_idle(input string tag);
        chk({tag, " req_ready"}, req_ready, 1);
        chk({tag, " ale"}, ale, 0);
        chk({tag, " rd_n"}, rd_n, 1);
        chk({tag, " wr_n"}, wr_n, 1);
        chk({tag, " ad_oe"}, ad_oe, 0);
        chk({tag, " ad_out"}, ad_out, 0);
        chk({tag, " a_hi"}, a_hi, 0);
        chk({tag, " status"}, {io_m, s1, s0}, 0);
    endtask

    // ph codes: 1=T1 2=T2 3=TW 4=T3 5=T4
    task automatic run_cycle(input int k, input logic [15:0] addr, input logic [7:0] wd,
                             input int nwait, input logic [7:0] rv);
        bit is_rd, is_wr, has_t4, is_halt;
        int w, nt, samples;
        is_rd   = (k == 0) || (k == 2) || (k == 4) || (k == 5);
        is_wr   = (k == 1) || (k == 3);
        has_t4  = (k == 4) || (k == 5);
        is_halt = (k >= 6);
        w  = is_halt ? 0 : nwait;
        nt = 6 + 2 * w + (has_t4 ? 2 : 0);
        samples = 0;

        @(negedge clk);
        chk("R1 idle before request", {req_ready, done}, 2'b10);
        chk_idle("R1");
        req_valid = 1'b1;
        req_kind  = 3'(k);
        req_addr  = addr;
        req_wdata = wd;
        ready     = 1'b0;

        for (int j = 0; j < nt; j++) begin
            int si, ph, h;
            bit strobe, e_rd, e_wr, e_oe;
            logic [7:0] e_ad;
            si = j / 2;
            h  = j % 2;
            if (si == 0) ph = 1;
            else if (si == 1) ph = 2;
            else if (si < 2 + w) ph = 3;
            else if (si == 2 + w) ph = 4;
            else ph = 5;

            @(negedge clk);
            // junk request while busy: must be dropped (R2)
            req_kind  = 3'(k + 3);
            req_addr  = ~addr;
            req_wdata = ~wd;
            req_valid = (j != nt - 1);
            // ready is 0 everywhere except on a sample edge that should pass (R8, R11)
            ready = 1'b0;
            if ((ph == 2 || ph == 3) && h == 0) begin
                if (samples >= nwait) ready = 1'b1;
                samples++;
            end
            ad_in = (ph == 4 && h == 0) ? rv : ~rv;

            strobe = (ph == 2) || (ph == 3) || (ph == 4);
            e_rd = is_rd && strobe;
            e_wr = is_wr && strobe && !(ph == 4 && h == 1);
            e_oe = (ph == 1) || (is_wr && strobe);
            e_ad = (ph == 1) ? addr[7:0] : (e_oe ? wd : 8'h00);

            chk("R2 req_ready low while busy", req_ready, 0);
            chk("R3 ale first half of T1", ale, (ph == 1 && h == 0));
            chk("R3 a_hi held", a_hi, addr[15:8]);
            chk("R4 status", {io_m, s1, s0}, exp_status(k));
            chk("R5 rd_n span", rd_n, !e_rd);
            chk("R7 wr_n span", wr_n, !e_wr);
            chk("R3 R7 ad_oe", ad_oe, e_oe);
            chk("R3 R7 ad_out", ad_out, e_ad);
            if (ph == 3) chk("R8 wait state output", {rd_n, wr_n}, {!is_rd, !is_wr});
            if (ph == 5) chk("R9 T4 quiet", {rd_n, wr_n, ad_oe}, 3'b110);
            if (is_halt) chk("R11 halt no strobe", {rd_n, wr_n, ph == 3}, 3'b110);
            chk("R10 no done while busy", done, 0);
        end

        @(negedge clk);
        if (is_rd) model_rdata = rv;
        chk("R10 done pulse", done, 1);
        chk("R10 req_ready with done", req_ready, 1);
        chk("R6 rdata captured", rdata, model_rdata);
        chk_idle("R2 junk ignored");
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT && !finished) begin
            finished = 1;
            failures++;
            $display("FAIL watchdog expired act=%0d exp<%0d", cyc, WD_LIMIT);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 reset done", done, 0);
        chk("R1 reset rdata", rdata, 0);
        chk_idle("R1 reset");

        run_cycle(0, 16'h12A5, 8'h00, 0, 8'h3C);   // memory read, no wait
        run_cycle(1, 16'h8034, 8'h5A, 0, 8'h00);   // memory write
        run_cycle(2, 16'h00F0, 8'h00, 2, 8'hC7);   // IO read, two waits
        run_cycle(3, 16'h0042, 8'hE1, 1, 8'h00);   // IO write, one wait
        run_cycle(4, 16'hBEEF, 8'h00, 0, 8'h76);   // fetch, T4
        run_cycle(4, 16'h0100, 8'h00, 1, 8'h99);   // fetch with wait
        run_cycle(5, 16'h0038, 8'h00, 0, 8'hFF);   // interrupt acknowledge
        run_cycle(6, 16'h7777, 8'h00, 3, 8'h11);   // halt, ready ignored
        run_cycle(7, 16'h0001, 8'h00, 0, 8'h22);   // alternate halt code
        run_cycle(0, 16'hFFFF, 8'h00, 3, 8'h00);   // memory read, three waits

        @(negedge clk);
        chk("R10 done one clock", done, 0);

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule